// File: doc/BRIEF.md
# Grouped Up-the-Ramp Slope Estimator

This block takes the pixel stream of a non-destructively read exposure ramp and turns it into one slope value per pixel. A ramp is made of N groups, each holding M consecutive frames. The block folds every sample into two running sums per pixel, kept in an internal RAM. At the end of the ramp it fits a least-squares line through the N group means, taken against the group index. Rather than dividing each group by M, the factor M is folded into the final denominator.

Samples arrive one pixel per accepted cycle in raster order. A frame marker and a ramp marker travel with the first sample they mark. The group count and the group size are sampled when a ramp begins. After the last pixel of the last frame has been taken, input is stalled and a sequential divider produces the slopes one pixel at a time. The slopes leave through a valid/ready handshake. Once the final slope has been accepted, the block is ready for the next ramp.

Top module: `ramp_slope_est`

## Requirements
- R1: After reset, out_valid and cfg_err are 0 and in_ready is 1.
- R2: A sample is taken when in_valid and in_ready are both 1. A sample with in_sor set is pixel 0 of frame 0 of a new ramp, and it latches N from cfg_groups and M from cfg_frames. A sample with in_sof set is pixel 0 of the next frame. Other samples take the following pixel index. Samples are unsigned DW-bit codes.
- R3: Frames f = 0 .. N·M−1 belong to group k = floor(f/M). The ramp closes when pixel NPIX−1 of frame N·M−1 is taken.
- R4: For each pixel, S0 is the sum of all its samples and S1 is the sum of k times each sample. The output is round(2^FRAC · (N·S1 − N(N−1)/2·S0) / (M·N²(N²−1)/12)) in two's complement with FRAC fraction bits, with ties rounded away from zero. This equals the least-squares slope of the group means per group step.
- R5: Slopes leave in pixel order 0 .. NPIX−1, one per cycle in which out_valid and out_ready are both 1. While out_valid is high and out_ready is low, out_valid stays high and out_slope does not change.
- R6: in_ready is 0 from the cycle after the ramp's last sample until the last slope has been accepted, and it returns to 1 afterwards.
- R7: A sample with in_sor taken during accumulation restarts the ramp. Sums gathered before it have no effect on the slopes.
- R8: While no ramp is open, samples without in_sor are accepted and discarded.
- R9: A sample with in_sor taken while cfg_groups < 2 or cfg_frames = 0 sets cfg_err from the next cycle. The samples that follow are discarded and no slope is produced. The next in_sor with a legal configuration clears cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_groups | input | GW | Group count N, sampled with in_sor |
| cfg_frames | input | MW | Frames per group M, sampled with in_sor |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | DW | Unsigned pixel sample |
| in_sof | input | 1 | Sample is pixel 0 of a new frame |
| in_sor | input | 1 | Sample is pixel 0 of a new ramp |
| out_valid | output | 1 | Slope valid |
| out_ready | input | 1 | Consumer takes the slope |
| out_slope | output | DW+FRAC+1 | Signed fixed-point slope |
| cfg_err | output | 1 | Illegal configuration at the last ramp start |

## Verification
Two situations are the hardest to reach from the ports. The first is a sum close to its full width. The stimulus drives a ramp with the largest N and M that the parameters allow, using full-scale samples, and then a full-scale rising ramp and a full-scale falling ramp. These push S0, S1 and the numerator to their extremes in both signs. The second is a restart in the middle of a ramp. The bench opens a ramp, writes garbage into part of it, then starts a new ramp, so that stale RAM contents sit under every pixel. Every slope is then compared with a bench model that rounds exactly, while out_ready is held low for random stretches during the drain.

// File: rtl/rse_pkg.sv
package rse_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_RD,
    ST_NUM,
    ST_DIV,
    ST_OUT
  } rse_state_t;
endpackage

// File: rtl/rse_sum_ram.sv
module rse_sum_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rse_round_div.sv
module rse_round_div #(
  parameter int NW   = 36,
  parameter int DSW  = 24,
  parameter int FRAC = 4,
  parameter int OW   = 21,
  localparam int QW  = NW + FRAC + 1,
  localparam int CW  = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] mag,
  input  logic          neg,
  input  logic [DSW-1:0] den,
  output logic          done,
  output logic [OW-1:0] quot
);
  logic [QW-1:0]  q;
  logic [DSW:0]   rem;
  logic [DSW-1:0] den_q;
  logic [CW-1:0]  cnt;
  logic           run;
  logic           neg_q;
  logic [DSW:0]   trial;

  assign trial = {rem[DSW-1:0], q[QW-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      q    <= '0;
      rem  <= '0;
      den_q <= '0;
      neg_q <= 1'b0;
    end else begin
      done <= run && (cnt == CW'(1));
      if (start) begin
        q     <= {1'b0, mag, {FRAC{1'b0}}} + QW'(den >> 1);
        rem   <= '0;
        den_q <= den;
        neg_q <= neg;
        cnt   <= CW'(QW);
        run   <= 1'b1;
      end else if (run) begin
        if (trial >= {1'b0, den_q}) begin
          rem <= trial - {1'b0, den_q};
          q   <= {q[QW-2:0], 1'b1};
        end else begin
          rem <= trial;
          q   <= {q[QW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) run <= 1'b0;
      end
    end
  end

  assign quot = neg_q ? (OW'(0) - q[OW-1:0]) : q[OW-1:0];
endmodule

// File: rtl/ramp_slope_est.sv
module ramp_slope_est #(
  parameter int NPIX = 16,
  parameter int DW   = 16,
  parameter int GW   = 5,
  parameter int MW   = 4,
  parameter int FRAC = 4,
  localparam int OW  = DW + FRAC + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] cfg_groups,
  input  logic [MW-1:0] cfg_frames,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_sor,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [OW-1:0] out_slope,
  output logic          cfg_err
);
  import rse_pkg::*;

  localparam int PAW  = (NPIX > 1) ? $clog2(NPIX) : 1;
  localparam int CNTW = $clog2(NPIX + 1);
  localparam int S0W  = DW + GW + MW;
  localparam int S1W  = DW + MW + 2 * GW;
  localparam int NUMW = S1W + GW + 2;
  localparam int MAGW = NUMW - 1;
  localparam int DSW  = MW + 4 * GW;
  localparam int RW   = S0W + S1W;

  rse_state_t state;
  logic [GW-1:0]    n_q, gidx;
  logic [MW-1:0]    m_q, fcnt;
  logic [2*GW-1:0]  tri_q;
  logic [DSW-1:0]   den_q;
  logic             frame0, err_q;
  logic [CNTW-1:0]  addr_cnt;
  logic [PAW-1:0]   dp;

  // configuration derived terms
  logic             cfg_bad;
  logic [2*GW-1:0]  nsq_c, tri_c;
  logic [4*GW-1:0]  nprod_c;
  logic [DSW-1:0]   den_c;

  always_comb begin
    cfg_bad = (cfg_groups < GW'(2)) || (cfg_frames == '0);
    nsq_c   = (2*GW)'(cfg_groups) * (2*GW)'(cfg_groups);
    nprod_c = (4*GW)'(nsq_c) * ((4*GW)'(nsq_c) - (4*GW)'(1));
    den_c   = DSW'(cfg_frames) * DSW'(nprod_c / (4*GW)'(12));
    tri_c   = ((2*GW)'(cfg_groups) * ((2*GW)'(cfg_groups) - (2*GW)'(1))) >> 1;
  end

  // current sample position
  logic            acc, take, last_c, first_c;
  logic [PAW-1:0]  pix_c;
  logic [GW-1:0]   k_c;
  logic [MW-1:0]   fc_c;

  assign in_ready = (state == ST_IDLE) || (state == ST_ACC);
  assign acc      = in_valid && in_ready;

  always_comb begin
    pix_c   = addr_cnt[PAW-1:0];
    k_c     = gidx;
    fc_c    = fcnt;
    first_c = frame0;
    if (in_sor) begin
      pix_c   = '0;
      k_c     = '0;
      fc_c    = '0;
      first_c = 1'b1;
    end else if (in_sof) begin
      pix_c   = '0;
      first_c = 1'b0;
      if (fcnt == m_q - MW'(1)) begin
        fc_c = '0;
        k_c  = gidx + GW'(1);
      end else begin
        fc_c = fcnt + MW'(1);
      end
    end
    take   = acc && (in_sor ? !cfg_bad
                            : (state == ST_ACC) && (in_sof || (addr_cnt < CNTW'(NPIX))));
    last_c = (k_c == n_q - GW'(1)) && (fc_c == m_q - MW'(1)) && (pix_c == PAW'(NPIX - 1));
  end

  // accumulate pipeline stage
  logic            s1_vld, s1_first;
  logic [PAW-1:0]  s1_addr;
  logic [DW-1:0]   s1_x;
  logic [GW-1:0]   s1_k;
  logic [RW-1:0]   rdata, wdata;
  logic [PAW-1:0]  raddr;
  logic [S0W-1:0]  rd_s0, new_s0;
  logic [S1W-1:0]  rd_s1, new_s1;

  assign rd_s0 = rdata[S0W-1:0];
  assign rd_s1 = rdata[RW-1:S0W];
  assign raddr = in_ready ? pix_c : dp;

  always_comb begin
    new_s0 = (s1_first ? S0W'(0) : rd_s0) + S0W'(s1_x);
    new_s1 = (s1_first ? S1W'(0) : rd_s1) + S1W'(s1_k) * S1W'(s1_x);
    wdata  = {new_s1, new_s0};
  end

  rse_sum_ram #(.DEPTH(NPIX), .WIDTH(RW)) u_ram (
    .clk   (clk),
    .we    (s1_vld),
    .waddr (s1_addr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  // numerator and divider
  logic [NUMW-1:0] num_c;
  logic            neg_c;
  logic [MAGW-1:0] mag_c;
  logic            div_done;
  logic [OW-1:0]   div_q;

  always_comb begin
    num_c = NUMW'(n_q) * NUMW'(rd_s1) - NUMW'(tri_q) * NUMW'(rd_s0);
    neg_c = num_c[NUMW-1];
    mag_c = neg_c ? MAGW'(NUMW'(0) - num_c) : num_c[MAGW-1:0];
  end

  rse_round_div #(.NW(MAGW), .DSW(DSW), .FRAC(FRAC), .OW(OW)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (state == ST_NUM),
    .mag   (mag_c),
    .neg   (neg_c),
    .den   (den_q),
    .done  (div_done),
    .quot  (div_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      n_q       <= '0;
      m_q       <= '0;
      tri_q     <= '0;
      den_q     <= '0;
      gidx      <= '0;
      fcnt      <= '0;
      frame0    <= 1'b0;
      addr_cnt  <= '0;
      err_q     <= 1'b0;
      dp        <= '0;
      s1_vld    <= 1'b0;
      s1_first  <= 1'b0;
      s1_addr   <= '0;
      s1_x      <= '0;
      s1_k      <= '0;
      out_valid <= 1'b0;
      out_slope <= '0;
    end else begin
      s1_vld   <= take;
      s1_addr  <= pix_c;
      s1_x     <= in_data;
      s1_k     <= k_c;
      s1_first <= first_c;
      if (acc && in_sor) begin
        n_q   <= cfg_groups;
        m_q   <= cfg_frames;
        tri_q <= tri_c;
        den_q <= den_c;
        err_q <= cfg_bad;
        state <= cfg_bad ? ST_IDLE : ST_ACC;
      end
      if (take) begin
        gidx     <= k_c;
        fcnt     <= fc_c;
        frame0   <= first_c;
        addr_cnt <= CNTW'(pix_c) + CNTW'(1);
        if (last_c) begin
          state <= ST_RD;
          dp    <= '0;
        end
      end
      case (state)
        ST_RD:  state <= ST_NUM;
        ST_NUM: state <= ST_DIV;
        ST_DIV: if (div_done) begin
          out_slope <= div_q;
          out_valid <= 1'b1;
          state     <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          if (dp == PAW'(NPIX - 1)) begin
            state <= ST_IDLE;
          end else begin
            dp    <= dp + PAW'(1);
            state <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/rse_checker.sv
module rse_checker #(
  parameter int DW   = 16,
  parameter int GW   = 5,
  parameter int MW   = 4,
  parameter int FRAC = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [GW-1:0]        cfg_groups,
  input logic [MW-1:0]        cfg_frames,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_sor,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [DW+FRAC:0]     out_slope,
  input logic                 cfg_err
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && !cfg_err));

  assert_stall_while_drain_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_hold_output_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slope)));

  assert_err_silent_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !out_valid);

  assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sor && (cfg_groups < GW'(2) || cfg_frames == '0)) |=> cfg_err);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_sor && cfg_groups >= GW'(2) && cfg_frames != '0) |=> !cfg_err);
endmodule

bind ramp_slope_est rse_checker #(.DW(DW), .GW(GW), .MW(MW), .FRAC(FRAC)) u_chk (.*);

// File: tb/ramp_slope_est_test.sv
module ramp_slope_est_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 16;
  localparam int DW   = 16;
  localparam int GW   = 5;
  localparam int MW   = 4;
  localparam int FRAC = 4;
  localparam int OW   = DW + FRAC + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [GW-1:0] cfg_groups = '0;
  logic [MW-1:0] cfg_frames = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sof = 1'b0;
  logic          in_sor = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_slope;
  logic          cfg_err;

  ramp_slope_est #(.NPIX(NPIX), .DW(DW), .GW(GW), .MW(MW), .FRAC(FRAC)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  longint e_s0 [NPIX];
  longint e_s1 [NPIX];

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_slope(longint s0, longint s1, int n, int m);
    longint num, den, mag, q;
    num = longint'(n) * s1 - longint'(n * (n - 1) / 2) * s0;
    den = longint'(m) * longint'(n) * longint'(n) * longint'(n * n - 1) / 12;
    mag = (num < 0) ? -num : num;
    q = (mag * (longint'(1) << FRAC) + den / 2) / den;
    return (num < 0) ? -q : q;
  endfunction

  function automatic int gen(int pat, int p, int f, int frames);
    int v;
    case (pat)
      0: v = 0;
      1: v = 65535;
      2: v = f * (65535 / (frames - 1));
      3: v = 65535 - f * (65535 / (frames - 1));
      default: v = p * 1500 + f * ((p * 53) % 400) + int'($urandom % 2048);
    endcase
    if (v > 65535) v = 65535;
    return v;
  endfunction

  task automatic push(int x, bit sof, bit sor);
    @(negedge clk);
    if ($urandom % 5 == 0) begin
      in_valid = 1'b0; in_sof = 1'b0; in_sor = 1'b0;
      @(negedge clk);
    end
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    in_sof   = sof;
    in_sor   = sor;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sor = 1'b0;
  endtask

  task automatic send_ramp(int n, int m, int pat);
    cfg_groups = GW'(n);
    cfg_frames = MW'(m);
    for (int f = 0; f < n * m; f++) begin
      for (int p = 0; p < NPIX; p++) begin
        int x;
        x = gen(pat, p, f, n * m);
        if (f == 0) begin
          e_s0[p] = 0;
          e_s1[p] = 0;
        end
        e_s0[p] += x;
        e_s1[p] += longint'(f / m) * x;
        push(x, p == 0, f == 0 && p == 0);
      end
    end
    idle();
  endtask

  // R4 R5 R6: slopes in pixel order, input stalled during drain
  task automatic drain_check(int n, int m, string req);
    check(in_ready == 1'b0, "R6 ready low after last sample", longint'(in_ready), 0);
    for (int p = 0; p < NPIX; p++) begin
      int guard = 0;
      bit got = 1'b0;
      while (!got && guard < 5000) begin
        @(negedge clk);
        out_ready = ($urandom % 3 != 0);
        got = out_valid && out_ready;
        guard++;
      end
      if (got) begin
        longint act;
        act = longint'($signed(out_slope));
        check(act == exp_slope(e_s0[p], e_s1[p], n, m), req, act,
              exp_slope(e_s0[p], e_s1[p], n, m));
        if (p == 0) check(in_ready == 1'b0, "R6 ready low while draining", longint'(in_ready), 0);
      end else begin
        check(1'b0, "R5 slope missing", 0, 1);
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R6 ready back after drain",
          longint'({in_ready, out_valid}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1311));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(out_valid == 1'b0 && cfg_err == 1'b0 && in_ready == 1'b1, "R1 reset state",
          longint'({out_valid, cfg_err, in_ready}), 1);

    send_ramp(22, 4, 4);  drain_check(22, 4, "R4 slope 22x4 random");
    send_ramp(6, 8, 2);   drain_check(6, 8, "R4 slope 6x8 rising full scale");
    send_ramp(2, 1, 3);   drain_check(2, 1, "R4 slope 2x1 falling full scale");
    send_ramp(3, 1, 4);   drain_check(3, 1, "R3 slope 3x1 random");
    send_ramp(31, 15, 1); drain_check(31, 15, "R3 slope 31x15 constant max");
    send_ramp(4, 3, 0);   drain_check(4, 3, "R4 slope 4x3 zero");

    // R8: frame without a ramp start is discarded
    cfg_groups = 5; cfg_frames = 2;
    for (int p = 0; p < NPIX; p++) push(60000 - p, p == 0, 1'b0);
    idle();
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 stray frame ignored",
          longint'({out_valid, in_ready}), 1);
    send_ramp(5, 2, 4);   drain_check(5, 2, "R8 slope after stray frame");

    // R7: restart in the middle of a ramp
    cfg_groups = 6; cfg_frames = 8;
    for (int f = 0; f < 3; f++)
      for (int p = 0; p < NPIX; p++) push(50000 - 700 * f, p == 0, f == 0 && p == 0);
    send_ramp(6, 8, 4);   drain_check(6, 8, "R7 slope after restart");

    // R9: illegal configurations
    cfg_groups = 1; cfg_frames = 4;
    for (int f = 0; f < 5; f++)
      for (int p = 0; p < NPIX; p++) push(1000 * f + p, p == 0, f == 0 && p == 0);
    idle();
    @(negedge clk);
    check(cfg_err == 1'b1 && in_ready == 1'b1, "R9 error for one group",
          longint'({cfg_err, in_ready}), 3);
    cfg_groups = 3; cfg_frames = 0;
    for (int p = 0; p < NPIX; p++) push(p, p == 0, p == 0);
    for (int f = 1; f < 4; f++)
      for (int p = 0; p < NPIX; p++) push(p + f, p == 0, 1'b0);
    idle();
    begin
      int seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      check(seen == 0 && cfg_err == 1'b1, "R9 no output on zero group size", seen, 0);
    end
    send_ramp(22, 4, 4);
    check(cfg_err == 1'b0, "R9 error cleared by legal ramp", longint'(cfg_err), 0);
    drain_check(22, 4, "R9 slope after error");

    // R2 R4: random configurations
    for (int t = 0; t < 3; t++) begin
      int n, m;
      n = 2 + int'($urandom % 10);
      m = 1 + int'($urandom % 6);
      send_ramp(n, m, 4);
      drain_check(n, m, "R2 slope random config");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule